// File: doc/BRIEF.md
# Indirect Target Predictor Entry Updater

This block sits in the training path of a tagged, history-indexed indirect-jump target predictor. Once an indirect jump resolves, the block takes the metadata captured at prediction time and the actual target. This metadata covers the longest-history hitting entry (the provider), the next-longest hitting entry (the alternate), the fallback target from the upstream predictor, and an allocation slot already chosen elsewhere. From these it produces, one cycle later, per-table write enables, write indices and complete new entry words for the storage arrays.

Each entry word holds a valid flag, a 9-bit tag, a 2-bit confidence counter, a 1-bit useful flag and a 41-bit target. The counter measures confidence that the stored target is right; it does not encode a direction. A provider counter of zero means the prediction actually used came from the alternate entry, or from the fallback target when no alternate hit. Choosing victims, clearing useful flags in bulk and the arrays themselves are outside this block.

Top module: `itgt_upd`

## Requirements
- R1: When `updValid` is low or `isIndirect` is low, no write enable is raised in the following cycle.
- R2: On an active update with `provided` high, the provider's table is written at `provIndex`. Its counter steps up by one if `provTarget` equals `actualTarget` and down by one otherwise, saturating at 3 and at 0.
- R3: A written provider or alternate entry takes `actualTarget` as its target when its counter was 0 at prediction time. Otherwise it keeps the target it reported.
- R4: The alternate table is written at `altIndex` only when `provided` is high, `provCtr` is 0 and `altProvided` is high. Its counter follows the rule of R2 against `altTarget`, and its useful flag is kept.
- R5: The provider useful flag becomes 1 when the provider was right and the alternate source was wrong. Otherwise, when the alternate hit with counter 0, it becomes 1 if the alternate was right and 0 if it was wrong. Otherwise it keeps `provUseful`. The alternate source is `altTarget` when `altProvided` is high and `baseTarget` otherwise.
- R6: With `allocValid` high, the allocation table is written at `allocIndex` when the alternate was not used and the final prediction was wrong. The entry holds valid 1, `allocTag`, counter 0, useful 0 and `actualTarget`. The final prediction is the alternate source when `provided` is high with `provCtr` 0, `provTarget` when `provided` is high otherwise, and `baseTarget` when `provided` is low.
- R7: With `provided` low, no provider or alternate write takes place; only an allocation can occur.
- R8: After reset all write enables are 0. Every write appears on the outputs exactly one clock after the update is presented.
- R9: Table t uses `wrIdx[t*IDX_W +: IDX_W]` and `wrData[t*54 +: 54]`. The entry word layout is target bits 40:0, useful bit 41, counter bits 43:42, tag bits 52:44 and valid bit 53. Every written word has valid 1 and the tag of its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| updValid | input | 1 | Update strobe |
| isIndirect | input | 1 | Resolved instruction is an indirect jump |
| provided | input | 1 | A provider entry hit |
| provTable | input | TBL_W | Provider table number |
| provIndex | input | IDX_W | Provider entry index |
| provTag | input | 9 | Provider tag |
| provCtr | input | 2 | Provider counter at prediction |
| provUseful | input | 1 | Provider useful flag at prediction |
| provTarget | input | 41 | Provider target |
| altProvided | input | 1 | An alternate entry hit |
| altTable | input | TBL_W | Alternate table number |
| altIndex | input | IDX_W | Alternate entry index |
| altTag | input | 9 | Alternate tag |
| altCtr | input | 2 | Alternate counter at prediction |
| altUseful | input | 1 | Alternate useful flag |
| altTarget | input | 41 | Alternate target |
| baseTarget | input | 41 | Fallback target from upstream predictor |
| allocValid | input | 1 | An allocation slot is offered |
| allocTable | input | TBL_W | Allocation table number |
| allocIndex | input | IDX_W | Allocation entry index |
| allocTag | input | 9 | Tag for the new entry |
| actualTarget | input | 41 | Resolved target |
| wrEn | output | NUM_TABLES | Per-table write enable |
| wrIdx | output | NUM_TABLES*IDX_W | Per-table write index |
| wrData | output | NUM_TABLES*54 | Per-table entry word |

## Verification
The hardest case to reach is one where several rules collide in one update. For example, a weak provider hands off to a weak alternate that is itself wrong while an allocation slot is on offer. Then the useful-flag priority, the alternate write and the suppression of allocation all depend on the same few bits. The stimulus sweeps every combination of hit flags, both counters, the correctness of each of the three candidate targets, the offered allocation and the old useful flag. It does this on two different table placements, so each collision is produced directly rather than waited for.

// File: rtl/itgt_upd_pkg.sv
package itgt_upd_pkg;
  localparam int TGT_W = 41;
  localparam int TAG_W = 9;
  localparam int CTR_W = 2;

  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
    logic [CTR_W-1:0] ctr;
    logic             useful;
    logic [TGT_W-1:0] target;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

  typedef struct packed {
    logic provWr;
    logic altWr;
    logic allocWr;
    logic provUp;
    logic altUp;
    logic provLoad;
    logic altLoad;
    logic provUseful;
  } strobe_t;

  function automatic logic [CTR_W-1:0] satStep(logic [CTR_W-1:0] c, logic up);
    if (up) return (c == '1) ? c : c + 1'b1;
    return (c == '0) ? c : c - 1'b1;
  endfunction
endpackage

// File: rtl/itgt_upd_ctrl.sv
module itgt_upd_ctrl
  import itgt_upd_pkg::*;
(
  input  logic             updValid,
  input  logic             isIndirect,
  input  logic             provided,
  input  logic [CTR_W-1:0] provCtr,
  input  logic             provUseful,
  input  logic             altProvided,
  input  logic [CTR_W-1:0] altCtr,
  input  logic             allocValid,
  input  logic             provMatch,
  input  logic             altMatch,
  input  logic             baseMatch,
  output strobe_t          stb
);
  logic active, useAlt, altSrcMatch, finalMatch, altWeak;

  always_comb begin
    active      = updValid && isIndirect;
    useAlt      = provided && (provCtr == '0);
    altSrcMatch = altProvided ? altMatch : baseMatch;
    if (useAlt)        finalMatch = altSrcMatch;
    else if (provided) finalMatch = provMatch;
    else               finalMatch = baseMatch;
    altWeak     = altProvided && (altCtr == '0);

    stb          = '0;
    stb.provWr   = active && provided;
    stb.altWr    = active && useAlt && altProvided;
    stb.allocWr  = active && allocValid && !useAlt && !finalMatch;
    stb.provUp   = provMatch;
    stb.altUp    = altMatch;
    stb.provLoad = (provCtr == '0);
    stb.altLoad  = (altCtr == '0);
    if (provMatch && !altSrcMatch) stb.provUseful = 1'b1;
    else if (altWeak)              stb.provUseful = altSrcMatch;
    else                           stb.provUseful = provUseful;
  end
endmodule

// File: rtl/itgt_upd_dpath.sv
module itgt_upd_dpath
  import itgt_upd_pkg::*;
#(
  parameter int NUM_TABLES = 5,
  parameter int IDX_W      = 9,
  parameter int TBL_W      = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  strobe_t                       stb,
  input  logic [TBL_W-1:0]              provTable,
  input  logic [IDX_W-1:0]              provIndex,
  input  logic [TAG_W-1:0]              provTag,
  input  logic [CTR_W-1:0]              provCtr,
  input  logic [TGT_W-1:0]              provTarget,
  input  logic [TBL_W-1:0]              altTable,
  input  logic [IDX_W-1:0]              altIndex,
  input  logic [TAG_W-1:0]              altTag,
  input  logic [CTR_W-1:0]              altCtr,
  input  logic                          altUseful,
  input  logic [TGT_W-1:0]              altTarget,
  input  logic [TGT_W-1:0]              baseTarget,
  input  logic [TBL_W-1:0]              allocTable,
  input  logic [IDX_W-1:0]              allocIndex,
  input  logic [TAG_W-1:0]              allocTag,
  input  logic [TGT_W-1:0]              actualTarget,
  output logic                          provMatch,
  output logic                          altMatch,
  output logic                          baseMatch,
  output logic [NUM_TABLES-1:0]         wrEn,
  output logic [NUM_TABLES*IDX_W-1:0]   wrIdx,
  output logic [NUM_TABLES*ENTRY_W-1:0] wrData
);
  entry_t provEnt, altEnt, allocEnt;

  assign provMatch = (provTarget == actualTarget);
  assign altMatch  = (altTarget == actualTarget);
  assign baseMatch = (baseTarget == actualTarget);

  always_comb begin
    provEnt.valid  = 1'b1;
    provEnt.tag    = provTag;
    provEnt.ctr    = satStep(provCtr, stb.provUp);
    provEnt.useful = stb.provUseful;
    provEnt.target = stb.provLoad ? actualTarget : provTarget;

    altEnt.valid   = 1'b1;
    altEnt.tag     = altTag;
    altEnt.ctr     = satStep(altCtr, stb.altUp);
    altEnt.useful  = altUseful;
    altEnt.target  = stb.altLoad ? actualTarget : altTarget;

    allocEnt.valid  = 1'b1;
    allocEnt.tag    = allocTag;
    allocEnt.ctr    = '0;
    allocEnt.useful = 1'b0;
    allocEnt.target = actualTarget;
  end

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_tbl
    logic             selProv, selAlt, selAlloc;
    logic             enQ;
    logic [IDX_W-1:0] idxQ;
    entry_t           dataQ;

    assign selProv  = stb.provWr  && (provTable  == TBL_W'(t));
    assign selAlt   = stb.altWr   && (altTable   == TBL_W'(t));
    assign selAlloc = stb.allocWr && (allocTable == TBL_W'(t));

    always_ff @(posedge clk) begin
      if (rst) begin
        enQ   <= 1'b0;
        idxQ  <= '0;
        dataQ <= '0;
      end else begin
        enQ <= selProv || selAlt || selAlloc;
        if (selProv) begin
          idxQ  <= provIndex;
          dataQ <= provEnt;
        end else if (selAlt) begin
          idxQ  <= altIndex;
          dataQ <= altEnt;
        end else if (selAlloc) begin
          idxQ  <= allocIndex;
          dataQ <= allocEnt;
        end
      end
    end

    assign wrEn[t]                     = enQ;
    assign wrIdx[t*IDX_W +: IDX_W]     = idxQ;
    assign wrData[t*ENTRY_W +: ENTRY_W] = dataQ;
  end
endmodule

// File: rtl/itgt_upd.sv
module itgt_upd
  import itgt_upd_pkg::*;
#(
  parameter int NUM_TABLES = 5,
  parameter int IDX_W      = 9,
  parameter int TBL_W      = (NUM_TABLES > 1) ? $clog2(NUM_TABLES) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          updValid,
  input  logic                          isIndirect,
  input  logic                          provided,
  input  logic [TBL_W-1:0]              provTable,
  input  logic [IDX_W-1:0]              provIndex,
  input  logic [TAG_W-1:0]              provTag,
  input  logic [CTR_W-1:0]              provCtr,
  input  logic                          provUseful,
  input  logic [TGT_W-1:0]              provTarget,
  input  logic                          altProvided,
  input  logic [TBL_W-1:0]              altTable,
  input  logic [IDX_W-1:0]              altIndex,
  input  logic [TAG_W-1:0]              altTag,
  input  logic [CTR_W-1:0]              altCtr,
  input  logic                          altUseful,
  input  logic [TGT_W-1:0]              altTarget,
  input  logic [TGT_W-1:0]              baseTarget,
  input  logic                          allocValid,
  input  logic [TBL_W-1:0]              allocTable,
  input  logic [IDX_W-1:0]              allocIndex,
  input  logic [TAG_W-1:0]              allocTag,
  input  logic [TGT_W-1:0]              actualTarget,
  output logic [NUM_TABLES-1:0]         wrEn,
  output logic [NUM_TABLES*IDX_W-1:0]   wrIdx,
  output logic [NUM_TABLES*ENTRY_W-1:0] wrData
);
  strobe_t stb;
  logic    provMatch, altMatch, baseMatch;

  itgt_upd_ctrl u_ctrl (
    .updValid   (updValid),
    .isIndirect (isIndirect),
    .provided   (provided),
    .provCtr    (provCtr),
    .provUseful (provUseful),
    .altProvided(altProvided),
    .altCtr     (altCtr),
    .allocValid (allocValid),
    .provMatch  (provMatch),
    .altMatch   (altMatch),
    .baseMatch  (baseMatch),
    .stb        (stb)
  );

  itgt_upd_dpath #(.NUM_TABLES(NUM_TABLES), .IDX_W(IDX_W), .TBL_W(TBL_W)) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .provTable   (provTable),
    .provIndex   (provIndex),
    .provTag     (provTag),
    .provCtr     (provCtr),
    .provTarget  (provTarget),
    .altTable    (altTable),
    .altIndex    (altIndex),
    .altTag      (altTag),
    .altCtr      (altCtr),
    .altUseful   (altUseful),
    .altTarget   (altTarget),
    .baseTarget  (baseTarget),
    .allocTable  (allocTable),
    .allocIndex  (allocIndex),
    .allocTag    (allocTag),
    .actualTarget(actualTarget),
    .provMatch   (provMatch),
    .altMatch    (altMatch),
    .baseMatch   (baseMatch),
    .wrEn        (wrEn),
    .wrIdx       (wrIdx),
    .wrData      (wrData)
  );
endmodule

// File: rtl/itgt_upd_chk.sv
module itgt_upd_chk
  import itgt_upd_pkg::*;
#(
  parameter int NUM_TABLES = 5,
  parameter int IDX_W      = 9,
  parameter int TBL_W      = 3
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          updValid,
  input logic                          isIndirect,
  input logic                          provided,
  input logic [TBL_W-1:0]              provTable,
  input logic [CTR_W-1:0]              provCtr,
  input logic [TGT_W-1:0]              provTarget,
  input logic [TGT_W-1:0]              baseTarget,
  input logic                          allocValid,
  input logic [TBL_W-1:0]              allocTable,
  input logic [TGT_W-1:0]              actualTarget,
  input logic [NUM_TABLES-1:0]         wrEn,
  input logic [NUM_TABLES*ENTRY_W-1:0] wrData
);
  localparam int CTR_LSB = TGT_W + 1;
  localparam int VLD_BIT = ENTRY_W - 1;

  p_ignore_r1: assert property (@(posedge clk) disable iff (rst)
    !(updValid && isIndirect) |=> (wrEn == '0));

  p_ctr_top_r2: assert property (@(posedge clk) disable iff (rst)
    (updValid && isIndirect && provided && provCtr == 2'd3 && provTarget == actualTarget)
    |=> (wrEn[$past(provTable)] &&
         wrData[$past(provTable)*ENTRY_W + CTR_LSB +: CTR_W] == 2'd3));

  p_ctr_floor_r2: assert property (@(posedge clk) disable iff (rst)
    (updValid && isIndirect && provided && provCtr == 2'd0 && provTarget != actualTarget)
    |=> (wrData[$past(provTable)*ENTRY_W + CTR_LSB +: CTR_W] == 2'd0));

  p_alloc_fresh_r6: assert property (@(posedge clk) disable iff (rst)
    (updValid && isIndirect && allocValid && !provided && baseTarget != actualTarget)
    |=> (wrEn[$past(allocTable)] &&
         wrData[$past(allocTable)*ENTRY_W +: TGT_W] == $past(actualTarget) &&
         wrData[$past(allocTable)*ENTRY_W + CTR_LSB +: CTR_W] == 2'd0));

  for (genvar t = 0; t < NUM_TABLES; t++) begin : g_vld
    p_valid_word_r9: assert property (@(posedge clk) disable iff (rst)
      wrEn[t] |-> wrData[t*ENTRY_W + VLD_BIT]);
  end
endmodule

bind itgt_upd itgt_upd_chk #(.NUM_TABLES(NUM_TABLES), .IDX_W(IDX_W), .TBL_W(TBL_W)) u_chk (
  .clk(clk), .rst(rst), .updValid(updValid), .isIndirect(isIndirect),
  .provided(provided), .provTable(provTable), .provCtr(provCtr),
  .provTarget(provTarget), .baseTarget(baseTarget), .allocValid(allocValid),
  .allocTable(allocTable), .actualTarget(actualTarget), .wrEn(wrEn), .wrData(wrData)
);

// File: tb/itgt_upd_test.sv
`timescale 1ns/1ps
module itgt_upd_test;
  localparam int NT = 5;
  localparam int IW = 9;
  localparam int TW = 3;
  localparam int EW = 54;

  logic clk = 1'b0;
  logic rst;
  logic updValid, isIndirect, provided, provUseful, altProvided, altUseful, allocValid;
  logic [TW-1:0] provTable, altTable, allocTable;
  logic [IW-1:0] provIndex, altIndex, allocIndex;
  logic [8:0] provTag, altTag, allocTag;
  logic [1:0] provCtr, altCtr;
  logic [40:0] provTarget, altTarget, baseTarget, actualTarget;
  logic [NT-1:0] wrEn;
  logic [NT*IW-1:0] wrIdx;
  logic [NT*EW-1:0] wrData;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  itgt_upd uut (
    .clk(clk), .rst(rst), .updValid(updValid), .isIndirect(isIndirect),
    .provided(provided), .provTable(provTable), .provIndex(provIndex), .provTag(provTag),
    .provCtr(provCtr), .provUseful(provUseful), .provTarget(provTarget),
    .altProvided(altProvided), .altTable(altTable), .altIndex(altIndex), .altTag(altTag),
    .altCtr(altCtr), .altUseful(altUseful), .altTarget(altTarget), .baseTarget(baseTarget),
    .allocValid(allocValid), .allocTable(allocTable), .allocIndex(allocIndex),
    .allocTag(allocTag), .actualTarget(actualTarget),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData)
  );

  // expected outputs, built from the requirements
  logic [NT-1:0]    expEn;
  logic [IW-1:0]    expIdx  [NT];
  logic [EW-1:0]    expData [NT];
  string            expReq  [NT];

  function automatic logic [1:0] stepCtr(logic [1:0] c, logic up);
    if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic buildExpect();
    logic act, pM, aM, bM, useAlt, srcM, finM, pu;
    act    = updValid && isIndirect;
    pM     = provTarget == actualTarget;
    aM     = altTarget == actualTarget;
    bM     = baseTarget == actualTarget;
    useAlt = provided && provCtr == 2'd0;
    srcM   = altProvided ? aM : bM;
    finM   = useAlt ? srcM : (provided ? pM : bM);
    for (int t = 0; t < NT; t++) begin
      expEn[t] = 1'b0; expIdx[t] = '0; expData[t] = '0; expReq[t] = "R7";
    end
    if (!act) begin
      for (int t = 0; t < NT; t++) expReq[t] = "R1";
      return;
    end
    // R5 useful priority
    if (pM && !srcM) pu = 1'b1;
    else if (altProvided && altCtr == 2'd0) pu = aM;
    else pu = provUseful;
    if (provided) begin  // R2 R3 R5 R9
      expEn[provTable] = 1'b1; expIdx[provTable] = provIndex; expReq[provTable] = "R2";
      expData[provTable] = {1'b1, provTag, stepCtr(provCtr, pM), pu,
                            (provCtr == 2'd0) ? actualTarget : provTarget};
    end
    if (useAlt && altProvided) begin  // R4 R3
      expEn[altTable] = 1'b1; expIdx[altTable] = altIndex; expReq[altTable] = "R4";
      expData[altTable] = {1'b1, altTag, stepCtr(altCtr, aM), altUseful,
                           (altCtr == 2'd0) ? actualTarget : altTarget};
    end
    if (allocValid && !useAlt && !finM) begin  // R6
      expEn[allocTable] = 1'b1; expIdx[allocTable] = allocIndex; expReq[allocTable] = "R6";
      expData[allocTable] = {1'b1, allocTag, 2'd0, 1'b0, actualTarget};
    end else if (allocValid) expReq[allocTable] = "R6";
  endtask

  task automatic compareAll();
    for (int t = 0; t < NT; t++) begin
      checks++;
      if (wrEn[t] !== expEn[t] ||
          (expEn[t] && (wrIdx[t*IW +: IW] !== expIdx[t] || wrData[t*EW +: EW] !== expData[t]))) begin
        errors++;
        $display("FAIL %s table %0d: en=%b idx=%0d data=%h expected en=%b idx=%0d data=%h",
                 expReq[t], t, wrEn[t], wrIdx[t*IW +: IW], wrData[t*EW +: EW],
                 expEn[t], expIdx[t], expData[t]);
      end
    end
  endtask

  // R8: drive at negedge, output registered at next posedge, sample at next negedge
  task automatic applyAndCheck();
    buildExpect();
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; updValid = 0; isIndirect = 0; provided = 0; provUseful = 0;
    altProvided = 0; altUseful = 0; allocValid = 0;
    provTable = 3'd3; altTable = 3'd1; allocTable = 3'd4;
    provIndex = 9'd300; altIndex = 9'd17; allocIndex = 9'd511;
    provTag = 9'h1A5; altTag = 9'h0C3; allocTag = 9'h155;
    provCtr = 0; altCtr = 0;
    provTarget = '0; altTarget = '0; baseTarget = '0; actualTarget = '0;
    repeat (3) @(negedge clk);
    // R8 reset state
    checks++;
    if (wrEn !== '0) begin
      errors++;
      $display("FAIL R8 reset: wrEn=%b expected=0", wrEn);
    end
    rst = 1'b0;
    @(negedge clk);

    // R1 ignore sweep: strobe or kind low with a fully armed update
    for (int k = 0; k < 3; k++) begin
      updValid = (k == 1); isIndirect = (k == 2);
      provided = 1; altProvided = 1; allocValid = 1; provCtr = 0; altCtr = 0;
      actualTarget = 41'h1_2345_6789; provTarget = 41'h7; altTarget = 41'h9;
      baseTarget = 41'h3;
      applyAndCheck();
    end

    // main sweep: R2 R3 R4 R5 R6 R7 R9
    updValid = 1; isIndirect = 1;
    for (int place = 0; place < 2; place++) begin
      provTable  = place ? 3'd2 : 3'd3;
      altTable   = place ? 3'd0 : 3'd1;
      allocTable = place ? 3'd3 : 3'd4;
      for (int n = 0; n < 2048; n++) begin
        logic pOk, aOk, bOk;
        provided    = n[0];
        provCtr     = n[2:1];
        pOk         = n[3];
        altProvided = n[4];
        altCtr      = n[6:5];
        aOk         = n[7];
        bOk         = n[8];
        allocValid  = n[9];
        provUseful  = n[10];
        altUseful   = ~n[10];
        actualTarget = {20'(n * 7 + place), 21'h0A5A5};
        provTarget   = pOk ? actualTarget : actualTarget ^ 41'h1;
        altTarget    = aOk ? actualTarget : actualTarget ^ 41'h2;
        baseTarget   = bOk ? actualTarget : actualTarget ^ 41'h4;
        applyAndCheck();
      end
    end

    updValid = 0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule